// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block sits on a host register bus and drives a raw NAND flash device. Software fills the address registers, a byte count and, for a program, the on-chip buffer RAM. It then writes one command word. That word chooses which bus phases run: an opcode cycle, one to eight address cycles, and a data burst in either direction. The sequencer runs the enabled phases in a fixed order and keeps the selected chip enable asserted for the whole command. When the last phase ends it sets a completion flag. The flag can also drive an interrupt line and is cleared by writing one to it.

Data moves between the host and the flash through a byte-wide buffer RAM. The host can reach the RAM with 8-bit or 16-bit accesses. On a program the sequencer reads bytes from RAM offset 0 upward. On a read it stores the sampled bytes there in the same order. A 16-bit bus mode moves two bytes per data cycle. Opcode and address cycles always use the low eight IO lines only.

Host accesses take effect in the cycle in which `host_req` is high. There is no back-pressure: the bus is always ready. `host_rdata` follows `host_addr` combinationally. The NAND pins are plain levels. The ready/busy inputs are synchronised inside the block before software sees them.

Top module: `nand_seq_top`

Register offsets:
- 0x000: control. Bit 0 enables the block. Writing 1 to bit 1 triggers a soft reset. Bit 2 selects the 16-bit bus. Bits 4:3 select the ready/busy line. Bits 11:8 hold the page code, which is log2(page bytes) minus 10. Bits 27:24 select the chip enable.
- 0x004: status.
- 0x008: interrupt enable, bit 1.
- 0x014: address low word.
- 0x018: address high word.
- 0x020: byte count, bits 9:0.
- 0x024: command word.
- 0x0A0: spare-area size, a plain 32-bit store.
- 0x400 to 0x7FF: buffer RAM.

## Requirements
- R1: After reset every chip enable, WE# and RE# are high, CLE, ALE, io_oe and irq are low, and the status busy bit 3 and done bit 1 read 0.
- R2: In the command word, bit 22 enables the opcode cycle (opcode in bits 7:0), bit 19 enables the address cycles and bit 21 enables the data phase. Enabled phases run in the order opcode, address, data. The done flag sets once, after the last enabled phase.
- R3: Every bus cycle holds its strobe (WE# or RE#) low for exactly 2 clocks and then high for 2 clocks. CLE is high only in opcode cycles and ALE only in address cycles.
- R4: The number of address cycles is command bits 18:16 plus one. Address byte k is taken from bits 8*(k mod 4)+7 : 8*(k mod 4) of the low word (0x014) for k<4, and of the high word (0x018) otherwise.
- R5: The chip enable chosen by control bits 27:24 is low from the cycle after the command is accepted until the command finishes, and all others stay high. Status bits 8+n show ready/busy input n, and status bit 0 shows the line chosen by control bits 4:3.
- R6: A data write (command bit 20 = 1) drives RAM bytes from offset 0 upward, one per cycle on io[7:0] in 8-bit mode. The count is taken from bits 9:0, where 0 means 1024 bytes.
- R7: In 16-bit mode (control bit 2) each data cycle carries two RAM bytes, the lower address on io[7:0]. Opcode and address cycles drive io[15:8] as zero.
- R8: A data read (command bit 20 = 0) samples the IO bus at the clock edge on which RE# rises. It stores the samples into RAM from offset 0 upward, and the host can read them there after completion.
- R9: Status bit 3 is high from the clock after the command write until the command finishes. Writing 1 to status bit 1 clears the done flag and writing 0 leaves it set. irq equals done AND interrupt-enable bit 1.
- R10: A command written while the sequencer is busy, or while control bit 0 is 0, produces no bus cycle and does not set busy.
- R11: Writing 1 to control bit 1 returns the sequencer to idle at once, releases all NAND pins and clears the done flag.
- R12: The host reaches the buffer RAM with 8-bit (host_half=0) or 16-bit (host_half=1, low byte at the even address) reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_half | input | 1 | RAM access size: 1 = 16-bit, 0 = 8-bit |
| host_addr | input | 12 | Byte address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Completion interrupt |
| nand_ce_n | output | 4 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 16 | IO bus drive value |
| nand_io_oe | output | 1 | IO bus output enable |
| nand_io_in | input | 16 | IO bus sampled value |
| nand_rb | input | 4 | Ready/busy lines |

## Verification
The bench builds the block with its default parameters: four chip enables, four ready/busy lines and a 1024-byte RAM (ten address bits). With these values the count-of-zero case, which means a full 1024-byte burst, stays short enough to run end to end. It also lets a non-zero chip-enable index and a non-zero ready/busy index be checked against the lines left idle. The 16-bit bus is chosen at run time, so both bus widths are covered in one build.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_ADDR,
    S_DATA,
    S_FIN
  } seq_state_t;

  typedef struct packed {
    logic [7:0] op;
    logic       cmd_en;
    logic       addr_en;
    logic [2:0] addr_n;
    logic       data_en;
    logic       dir_wr;
  } cmd_word_t;

  localparam logic [11:0] OFS_CTL   = 12'h000;
  localparam logic [11:0] OFS_STAT  = 12'h004;
  localparam logic [11:0] OFS_IEN   = 12'h008;
  localparam logic [11:0] OFS_ALO   = 12'h014;
  localparam logic [11:0] OFS_AHI   = 12'h018;
  localparam logic [11:0] OFS_CNT   = 12'h020;
  localparam logic [11:0] OFS_CMD   = 12'h024;
  localparam logic [11:0] OFS_SPARE = 12'h0A0;

  function automatic cmd_word_t decode_cmd(input logic [31:0] w);
    cmd_word_t c;
    c.op      = w[7:0];
    c.cmd_en  = w[22];
    c.addr_en = w[19];
    c.addr_n  = w[18:16];
    c.data_en = w[21];
    c.dir_wr  = w[20];
    return c;
  endfunction

endpackage

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          h_we,
  input  logic          h_half,
  input  logic [AW-1:0] h_addr,
  input  logic [15:0]   h_wdata,
  output logic [15:0]   h_rdata,
  input  logic          s_we,
  input  logic          s_wide,
  input  logic [AW-1:0] s_ptr,
  input  logic [15:0]   s_wdata,
  output logic [15:0]   s_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] h_even, h_odd, s_next;

  assign h_even  = {h_addr[AW-1:1], 1'b0};
  assign h_odd   = {h_addr[AW-1:1], 1'b1};
  assign s_next  = s_ptr + AW'(1);
  assign h_rdata = {mem[h_odd], mem[h_even]};
  assign s_rdata = {mem[s_next], mem[s_ptr]};

  // sequencer port wins a same-cycle collision
  always_ff @(posedge clk) begin
    if (s_we) begin
      mem[s_ptr] <= s_wdata[7:0];
      if (s_wide) mem[s_next] <= s_wdata[15:8];
    end else if (h_we) begin
      if (h_half) begin
        mem[h_even] <= h_wdata[7:0];
        mem[h_odd]  <= h_wdata[15:8];
      end else begin
        mem[h_addr] <= h_wdata[7:0];
      end
    end
  end
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int NUM_RB   = 4,
  parameter int CNT_W    = 10,
  parameter int CE_SEL_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [11:0]         host_addr,
  input  logic [31:0]         host_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                seq_busy_i,
  input  logic                seq_done_i,
  input  logic [NUM_RB-1:0]   rb_i,
  output logic                start_o,
  output cmd_word_t           cmd_o,
  output logic                srst_o,
  output logic                wide_o,
  output logic [CE_SEL_W-1:0] ce_sel_o,
  output logic [31:0]         addr_lo_o,
  output logic [31:0]         addr_hi_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                irq_o
);
  logic                wr;
  logic                en_q, wide_q, ien_q, done_q, rb_lvl;
  logic [1:0]          rbsel_q;
  logic [3:0]          pg_q;
  logic [CE_SEL_W-1:0] ce_q;
  logic [31:0]         alo_q, ahi_q, spare_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [NUM_RB-1:0]   rb_m, rb_s;

  assign wr       = host_req && host_we;
  assign srst_o   = wr && host_addr == OFS_CTL && host_wdata[1];
  assign start_o  = wr && host_addr == OFS_CMD && en_q && !seq_busy_i;
  assign cmd_o    = decode_cmd(host_wdata);
  assign wide_o   = wide_q;
  assign ce_sel_o = ce_q;
  assign addr_lo_o = alo_q;
  assign addr_hi_o = ahi_q;
  assign cnt_o    = cnt_q;
  assign irq_o    = done_q && ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_m <= '0;
      rb_s <= '0;
    end else begin
      rb_m <= rb_i;
      rb_s <= rb_m;
    end
  end

  always_comb begin
    rb_lvl = 1'b0;
    for (int i = 0; i < NUM_RB; i++)
      if (rbsel_q == 2'(i)) rb_lvl = rb_s[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; wide_q <= 1'b0; rbsel_q <= '0; pg_q <= '0; ce_q <= '0;
      ien_q <= 1'b0; alo_q <= '0; ahi_q <= '0; cnt_q <= '0; spare_q <= '0;
    end else if (wr) begin
      case (host_addr)
        OFS_CTL: begin
          en_q    <= host_wdata[0];
          wide_q  <= host_wdata[2];
          rbsel_q <= host_wdata[4:3];
          pg_q    <= host_wdata[11:8];
          ce_q    <= host_wdata[24 +: CE_SEL_W];
        end
        OFS_IEN:   ien_q   <= host_wdata[1];
        OFS_ALO:   alo_q   <= host_wdata;
        OFS_AHI:   ahi_q   <= host_wdata;
        OFS_CNT:   cnt_q   <= host_wdata[CNT_W-1:0];
        OFS_SPARE: spare_q <= host_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          done_q <= 1'b0;
    else if (srst_o)                                     done_q <= 1'b0;
    else if (seq_done_i)                                 done_q <= 1'b1;
    else if (wr && host_addr == OFS_STAT && host_wdata[1]) done_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (host_addr)
      OFS_CTL: begin
        reg_rdata[0]    = en_q;
        reg_rdata[2]    = wide_q;
        reg_rdata[4:3]  = rbsel_q;
        reg_rdata[11:8] = pg_q;
        reg_rdata[24 +: CE_SEL_W] = ce_q;
      end
      OFS_STAT: begin
        reg_rdata[0] = rb_lvl;
        reg_rdata[1] = done_q;
        reg_rdata[3] = seq_busy_i;
        reg_rdata[8 +: NUM_RB] = rb_s;
      end
      OFS_IEN:   reg_rdata[1] = ien_q;
      OFS_ALO:   reg_rdata = alo_q;
      OFS_AHI:   reg_rdata = ahi_q;
      OFS_CNT:   reg_rdata[CNT_W-1:0] = cnt_q;
      OFS_SPARE: reg_rdata = spare_q;
      default: ;
    endcase
  end

  // R9: the done flag only rises after the sequencer reports completion
  a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(seq_done_i));

endmodule

// File: rtl/nand_seq_ctl.sv
module nand_seq_ctl
  import nand_seq_pkg::*;
#(
  parameter int NUM_CE   = 4,
  parameter int AW       = 10,
  parameter int CE_SEL_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                srst_i,
  input  logic                start_i,
  input  cmd_word_t           cmd_i,
  input  logic                wide_i,
  input  logic [CE_SEL_W-1:0] ce_sel_i,
  input  logic [31:0]         addr_lo_i,
  input  logic [31:0]         addr_hi_i,
  input  logic [AW-1:0]       cnt_i,
  input  logic [15:0]         io_in_i,
  input  logic [15:0]         buf_rdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [NUM_CE-1:0]   ce_n_o,
  output logic                cle_o,
  output logic                ale_o,
  output logic                we_n_o,
  output logic                re_n_o,
  output logic [15:0]         io_out_o,
  output logic                io_oe_o,
  output logic                buf_we_o,
  output logic                buf_wide_o,
  output logic [AW-1:0]       buf_ptr_o,
  output logic [15:0]         buf_wdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  seq_state_t          state;
  logic [1:0]          tick;
  cmd_word_t           cmd_q;
  logic                wide_q;
  logic [CE_SEL_W-1:0] ce_q;
  logic [63:0]         addr_q;
  logic [2:0]          aidx;
  logic [PW-1:0]       ptr, total, step;
  logic                cyc_end, last_beat, low;
  logic                is_cmd, is_addr, is_data, drv;

  function automatic seq_state_t after_cmd(input cmd_word_t c);
    if (c.addr_en)      return S_ADDR;
    else if (c.data_en) return S_DATA;
    else                return S_FIN;
  endfunction

  function automatic seq_state_t after_addr(input cmd_word_t c);
    return c.data_en ? S_DATA : S_FIN;
  endfunction

  assign step      = wide_q ? PW'(2) : PW'(1);
  assign last_beat = (ptr + step) >= total;
  assign cyc_end   = (tick == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tick <= '0; cmd_q <= '0; wide_q <= 1'b0; ce_q <= '0;
      addr_q <= '0; aidx <= '0; ptr <= '0; total <= '0;
    end else if (srst_i) begin
      state <= S_IDLE;
      tick  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          cmd_q  <= cmd_i;
          wide_q <= wide_i;
          ce_q   <= ce_sel_i;
          addr_q <= {addr_hi_i, addr_lo_i};
          total  <= (cnt_i == '0) ? PW'(DEPTH) : {1'b0, cnt_i};
          aidx   <= '0;
          ptr    <= '0;
          tick   <= '0;
          state  <= cmd_i.cmd_en ? S_CMD : after_cmd(cmd_i);
        end
        S_CMD: begin
          tick <= tick + 2'd1;
          if (cyc_end) state <= after_cmd(cmd_q);
        end
        S_ADDR: begin
          tick <= tick + 2'd1;
          if (cyc_end) begin
            if (aidx == cmd_q.addr_n) state <= after_addr(cmd_q);
            else aidx <= aidx + 3'd1;
          end
        end
        S_DATA: begin
          tick <= tick + 2'd1;
          if (cyc_end) begin
            if (last_beat) state <= S_FIN;
            else ptr <= ptr + step;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (state != S_IDLE);
  assign done_o  = (state == S_FIN);
  assign is_cmd  = (state == S_CMD);
  assign is_addr = (state == S_ADDR);
  assign is_data = (state == S_DATA);
  assign low     = !tick[1];
  assign drv     = is_cmd || is_addr || (is_data && cmd_q.dir_wr);

  assign cle_o   = is_cmd;
  assign ale_o   = is_addr;
  assign we_n_o  = !(drv && low);
  assign re_n_o  = !(is_data && !cmd_q.dir_wr && low);
  assign io_oe_o = drv;

  always_comb begin
    io_out_o = '0;
    if (is_cmd)       io_out_o = {8'h00, cmd_q.op};
    else if (is_addr) io_out_o = {8'h00, addr_q[{aidx, 3'b000} +: 8]};
    else if (is_data && cmd_q.dir_wr)
      io_out_o = wide_q ? buf_rdata_i : {8'h00, buf_rdata_i[7:0]};
  end

  assign buf_we_o    = is_data && !cmd_q.dir_wr && (tick == 2'd1);
  assign buf_wide_o  = wide_q;
  assign buf_ptr_o   = ptr[AW-1:0];
  assign buf_wdata_o = io_in_i;

  for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
    assign ce_n_o[i] = !(busy_o && ce_q == CE_SEL_W'(i));
  end

  a_r3_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_o && ale_o));
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !re_n_o));
  a_r3_latch_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cle_o || ale_o) |-> re_n_o);
  a_r5_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n_o));
  a_r7_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cle_o || ale_o) |-> io_out_o[15:8] == 8'h00);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r11_srst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> !busy_o);

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int NUM_CE = 4,
  parameter int NUM_RB = 4,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic              host_half,
  input  logic [11:0]       host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              irq,
  output logic [NUM_CE-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [15:0]       nand_io_out,
  output logic              nand_io_oe,
  input  logic [15:0]       nand_io_in,
  input  logic [NUM_RB-1:0] nand_rb
);
  localparam int HAW      = 12;
  localparam int CE_SEL_W = 4;

  logic                in_ram;
  logic [31:0]         reg_rdata, alo, ahi;
  logic                start, srst, busy, done, wide;
  cmd_word_t           cmd;
  logic [CE_SEL_W-1:0] ce_sel;
  logic [AW-1:0]       cnt, b_ptr;
  logic [15:0]         h_rd, s_rd, s_wd;
  logic                b_we, b_wide;
  logic [7:0]          h_byte;

  assign in_ram = (host_addr[HAW-1:AW] == (HAW-AW)'(1));
  assign h_byte = host_addr[0] ? h_rd[15:8] : h_rd[7:0];
  assign host_rdata = !in_ram    ? reg_rdata :
                      host_half ? {16'h0000, h_rd} : {24'h000000, h_byte};

  nand_seq_regs #(.NUM_RB(NUM_RB), .CNT_W(AW), .CE_SEL_W(CE_SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req && !in_ram), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .reg_rdata(reg_rdata),
    .seq_busy_i(busy), .seq_done_i(done), .rb_i(nand_rb),
    .start_o(start), .cmd_o(cmd), .srst_o(srst), .wide_o(wide),
    .ce_sel_o(ce_sel), .addr_lo_o(alo), .addr_hi_o(ahi), .cnt_o(cnt),
    .irq_o(irq)
  );

  nand_seq_ctl #(.NUM_CE(NUM_CE), .AW(AW), .CE_SEL_W(CE_SEL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .srst_i(srst), .start_i(start), .cmd_i(cmd),
    .wide_i(wide), .ce_sel_i(ce_sel), .addr_lo_i(alo), .addr_hi_i(ahi),
    .cnt_i(cnt), .io_in_i(nand_io_in), .buf_rdata_i(s_rd),
    .busy_o(busy), .done_o(done), .ce_n_o(nand_ce_n),
    .cle_o(nand_cle), .ale_o(nand_ale), .we_n_o(nand_we_n), .re_n_o(nand_re_n),
    .io_out_o(nand_io_out), .io_oe_o(nand_io_oe),
    .buf_we_o(b_we), .buf_wide_o(b_wide), .buf_ptr_o(b_ptr), .buf_wdata_o(s_wd)
  );

  nand_seq_buf #(.AW(AW)) u_buf (
    .clk(clk),
    .h_we(host_req && host_we && in_ram), .h_half(host_half),
    .h_addr(host_addr[AW-1:0]), .h_wdata(host_wdata[15:0]), .h_rdata(h_rd),
    .s_we(b_we), .s_wide(b_wide), .s_ptr(b_ptr), .s_wdata(s_wd), .s_rdata(s_rd)
  );

endmodule

// File: tb/nand_seq_top_tb_top.sv
module nand_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0, host_half = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [15:0] nand_io_out, nand_io_in;
  logic [3:0]  nand_rb = 4'b1010;

  int checks = 0, fails = 0;
  int rd_idx = 0, evt_we = 0, evt_re = 0, lowcnt = 0;
  bit was_rd = 0, check_on = 1;
  logic [3:0] exp_ce = 4'b1011;

  typedef struct packed { logic [1:0] kind; logic [15:0] dat; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  assign nand_io_in = 16'hC3A0 + rd_idx[15:0];

  nand_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_half(host_half), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit half = 0);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d; host_half = half;
    @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input bit half, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_half = half;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 8000; i++) begin
      rd(12'h004, 0, s);
      if (!s[3]) return;
    end
    chk(0, "R9 busy never cleared", 1, 0);
  endtask

  task automatic push(input logic [1:0] k, input logic [15:0] d);
    q.push_back({k, d});
  endtask

  // monitor: one event per strobe-low window, compared with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n || !nand_re_n) begin
        if (lowcnt == 0) begin
          if (!nand_we_n) evt_we++; else begin evt_re++; was_rd = 1; end
          if (check_on) begin
            if (q.size() == 0) chk(0, "R10 unexpected bus cycle", {16'h0, nand_io_out}, 0);
            else begin
              exp_t e, a;
              e = q.pop_front();
              a.kind = !nand_re_n ? 2'd3 : nand_cle ? 2'd0 : nand_ale ? 2'd1 : 2'd2;
              a.dat  = !nand_re_n ? e.dat : nand_io_out;
              chk(a == e && (nand_io_oe == nand_re_n), "R2 R4 R6 R7 bus cycle", 32'(a), 32'(e));
              chk(nand_ce_n == exp_ce, "R5 chip enable", 32'(nand_ce_n), 32'(exp_ce));
            end
          end
        end
        lowcnt++;
      end else if (lowcnt != 0) begin
        if (check_on) chk(lowcnt == 2, "R3 strobe low width", lowcnt, 2);
        lowcnt = 0;
        if (was_rd) begin rd_idx++; was_rd = 0; end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog R1..R12", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base, ev0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nand_ce_n == 4'hF && !nand_cle && !nand_ale && nand_we_n && nand_re_n &&
        !nand_io_oe && !irq, "R1 idle pins", 32'(nand_ce_n), 32'hF);
    rd(12'h004, 0, d);
    chk(d == 32'h0000_0A00, "R1 R5 status after reset", d, 32'h0000_0A00);
    // R5 ready/busy select
    wr(12'h000, 32'h0200_0109);
    wr(12'h0A0, 32'd2048);
    rd(12'h004, 0, d);
    chk(d[0] == 1'b1, "R5 selected rb line", d, 1);

    // opcode-only command, done flag and irq
    push(0, 16'h0070);
    wr(12'h024, 32'h0040_0070);
    wait_idle();
    rd(12'h004, 0, d);
    chk(d[1] && q.size() == 0, "R2 done after opcode", d, 2);
    chk(!irq, "R9 irq masked", 32'(irq), 0);
    wr(12'h008, 32'h2);
    #1 chk(irq, "R9 irq enabled", 32'(irq), 1);
    wr(12'h004, 32'h0);
    rd(12'h004, 0, d);
    chk(d[1], "R9 write 0 keeps done", d[1], 1);
    wr(12'h004, 32'h2);
    rd(12'h004, 0, d);
    chk(!d[1] && !irq, "R9 W1C clears done", d[1], 0);

    // full write: opcode, 6 address bytes, 5 data bytes; busy write ignored
    wr(12'h014, 32'h4433_2211);
    wr(12'h018, 32'h0000_6655);
    wr(12'h020, 32'd5);
    for (int i = 0; i < 5; i++) wr(12'h400 + 12'(i), 32'h5A + 32'(i * 17));
    rd(12'h402, 0, d);
    chk(d == 32'h5A + 34, "R12 byte RAM readback", d, 32'h5A + 34);
    push(0, 16'h0080);
    for (int k = 0; k < 6; k++) push(1, 16'h11 * 16'(k + 1));
    for (int i = 0; i < 5; i++) push(2, 16'h5A + 16'(i * 17));
    ev0 = evt_we;
    wr(12'h024, 32'h007D_0080);
    rd(12'h004, 0, d);
    chk(d[3], "R9 busy after command", d, 8);
    wr(12'h024, 32'h0040_00FF);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(q.size() == 0 && evt_we - ev0 == 12, "R10 busy command ignored", evt_we - ev0, 12);
    #1 chk(nand_ce_n == 4'hF, "R5 CE released", 32'(nand_ce_n), 32'hF);

    // 8-bit read of 3 bytes
    wr(12'h004, 32'h2);
    wr(12'h020, 32'd3);
    base = rd_idx;
    for (int i = 0; i < 3; i++) push(3, 16'h0);
    wr(12'h024, 32'h0020_0000);
    wait_idle();
    for (int i = 0; i < 3; i++) begin
      rd(12'h400 + 12'(i), 0, d);
      chk(d == 32'((8'hA0 + 8'(base + i))), "R8 read byte stored", d, 32'((8'hA0 + 8'(base + i))));
    end

    // 16-bit mode write
    wr(12'h000, 32'h0200_010D);
    wr(12'h400, 32'hBEEF, 1);
    wr(12'h402, 32'hCAFE, 1);
    rd(12'h402, 1, d);
    chk(d == 32'hCAFE, "R12 half RAM readback", d, 32'hCAFE);
    wr(12'h020, 32'd4);
    push(0, 16'h0010); push(2, 16'hBEEF); push(2, 16'hCAFE);
    wr(12'h024, 32'h0070_0010);
    wait_idle();
    chk(q.size() == 0, "R7 wide write done", q.size(), 0);

    // 16-bit mode read
    wr(12'h020, 32'd2);
    base = rd_idx;
    push(3, 16'h0);
    wr(12'h024, 32'h0020_0000);
    wait_idle();
    rd(12'h400, 1, d);
    chk(d == 32'(16'hC3A0 + 16'(base)), "R7 R8 wide read", d, 32'(16'hC3A0 + 16'(base)));

    // disabled block ignores commands
    wr(12'h000, 32'h0200_0108);
    ev0 = evt_we;
    wr(12'h024, 32'h0040_0033);
    rd(12'h004, 0, d);
    repeat (10) @(negedge clk);
    chk(!d[3] && evt_we == ev0, "R10 disabled command ignored", d, 0);

    // count zero means 1024 bytes
    check_on = 0;
    wr(12'h000, 32'h0200_0109);
    wr(12'h020, 32'd0);
    ev0 = evt_we;
    wr(12'h024, 32'h0030_0000);
    wait_idle();
    chk(evt_we - ev0 == 1024, "R6 count zero is 1024", evt_we - ev0, 1024);

    // soft reset mid-burst
    wr(12'h024, 32'h0030_0000);
    repeat (50) @(negedge clk);
    wr(12'h000, 32'h0200_010B);
    #1 chk(nand_ce_n == 4'hF && nand_we_n && nand_re_n && !nand_io_oe,
           "R11 pins idle after soft reset", 32'(nand_ce_n), 32'hF);
    rd(12'h004, 0, d);
    chk(!d[3] && !d[1], "R11 busy and done cleared", d, 32'h0000_0A01);
    lowcnt = 0;

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule